// File: doc/BRIEF.md
# Destination Address Filter with Loadable Match Table

This block decides, for each incoming frame, whether its 48-bit destination address is wanted. Three mode inputs select promiscuous acceptance of individual addresses, acceptance of every group (multicast) address, and acceptance of the all-ones broadcast address. A 16-entry match table with a per-entry enable mask covers everything else. The verdict appears one clock after the address strobe, together with a multicast or broadcast flag that tells the receive path why the frame was taken.

The match table is filled by a built-in sequencer. Software writes the table image into memory as a run of four-field descriptors. A load command gives a start pointer and an entry count. The sequencer then walks the descriptors over a simple request/acknowledge read port and fetches one further descriptor, whose first field becomes the enable mask. It pulses done when it has finished. While the surrounding receiver is held in its software-reset state, a debug port returns any 16-bit slice of any table entry.

Top module: `addr_filter_cam`

## Requirements
- R1: When `mode_promisc` is 1 and address bit 0 (the group bit of byte 0, held in `dst_addr[0]`) is 0, the frame is accepted with both flags 0. No other rule is consulted.
- R2: Otherwise, when `mode_all_mcast` is 1 and `dst_addr[0]` is 1, the frame is accepted with `res_mcast`=1 and `res_bcast`=0. This includes the broadcast address.
- R3: Otherwise, when `mode_bcast` is 1 and all 48 address bits are 1, the frame is accepted with `res_bcast`=1 and `res_mcast`=0.
- R4: Otherwise the frame is accepted with both flags 0 exactly when some table entry i whose enable-mask bit i is 1 equals the address. If no enabled entry matches, it is rejected with all outputs 0.
- R5: `res_valid` and the verdict are registered. They appear on the first clock edge after the cycle in which `dst_valid` is 1 and are valid for that one cycle only. The mode inputs are sampled in the strobe cycle.
- R6: On `load_start` while idle, the sequencer performs the following loop as long as its 5-bit count is nonzero. It reads descriptor fields 1, 2 and 3 at pointer + field x step and writes entry n as bytes {f3,f2,f1}, where the low byte of a field is the lower-numbered address byte. It then moves to the next entry, decrements the count and adds 4 x step to the pointer. The step is 2 bytes in narrow mode and 4 bytes when `load_wide` is 1, and only the low 16 bits of a read are used. Entries start at 0 and the index wraps modulo 16.
- R7: After the entries, field 0 of the descriptor at the final pointer becomes the enable mask. Entries at or beyond the count keep their contents. A count of 0 loads only the mask.
- R8: `mem_req` is 1 only while `load_busy` is 1, and `mem_addr` is held until `mem_ack`. `load_done` is a single-cycle pulse in the cycle in which `load_busy` falls.
- R9: While `sw_reset` is 1, `dbg_data` returns bytes {2k+1, 2k} of entry `dbg_ptr` for `dbg_sel`=k (0..2), and 0 for `dbg_sel`=3. While `sw_reset` is 0 it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dst_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| mode_promisc | input | 1 | Accept all individual addresses |
| mode_all_mcast | input | 1 | Accept all group addresses |
| mode_bcast | input | 1 | Accept the broadcast address |
| res_valid | output | 1 | Verdict valid |
| res_accept | output | 1 | Frame accepted |
| res_mcast | output | 1 | Accepted as multicast |
| res_bcast | output | 1 | Accepted as broadcast |
| load_start | input | 1 | Start a table load |
| load_wide | input | 1 | 32-bit descriptor field spacing |
| load_ptr | input | 16 | Byte address of first descriptor |
| load_count | input | 5 | Number of entries to load |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | Load finished pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| sw_reset | input | 1 | Receiver held in software reset |
| dbg_ptr | input | 4 | Entry index for debug read |
| dbg_sel | input | 2 | 16-bit slice select |
| dbg_data | output | 16 | Debug read data |

## Verification
A corrupted table entry or enable bit shows up at the debug port as soon as the load completes. It also shows up at the verdict one cycle after any strobe carrying that entry's address, so the bench reads back every slice of every entry and strobes every entry's address under all eight mode combinations. A sequencer that strays in pointer, step or count writes wrong bytes into the table or the mask, or disturbs entries beyond the count. Each of these faults appears at the debug port within the load's own completion. Priority mistakes appear on the verdict and flags of the first strobe that straddles two rules, such as the broadcast address under all-multicast mode.

// File: rtl/afc_pkg.sv
package afc_pkg;
   typedef enum logic [1:0] {
      LD_IDLE  = 2'd0,
      LD_TEST  = 2'd1,
      LD_FETCH = 2'd2
   } ld_state_e;

   localparam logic [1:0] FLD_MASK = 2'd0;
   localparam logic [1:0] FLD_LO   = 2'd1;
   localparam logic [1:0] FLD_MID  = 2'd2;
   localparam logic [1:0] FLD_HI   = 2'd3;

   typedef struct packed {
      logic accept;
      logic mcast;
      logic bcast;
   } verdict_t;
endpackage

// File: rtl/afc_cam.sv
module afc_cam #(
   parameter int unsigned N_ENTRIES      = 16,
   parameter int unsigned AW             = 48,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [$clog2(N_ENTRIES)-1:0] wr_idx,
   input  logic [AW-1:0]                wr_data,
   input  logic                         mask_we,
   input  logic [N_ENTRIES-1:0]         mask_data,
   input  logic [AW-1:0]                key,
   output logic [N_ENTRIES-1:0]         hit,
   input  logic [$clog2(N_ENTRIES)-1:0] rd_idx,
   output logic [AW-1:0]                rd_data
);
   localparam int unsigned IDX_W = $clog2(N_ENTRIES);

   logic [AW-1:0]        ent_q [N_ENTRIES];
   logic [N_ENTRIES-1:0] en_q;
   logic [N_ENTRIES-1:0] match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (mask_we) en_q <= mask_data;
   end

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(i));
      if (CLEAR_ON_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ent_q[i] <= '0;
            else if (sel) ent_q[i] <= wr_data;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (sel) ent_q[i] <= wr_data;
         end
      end
      assign match[i] = (ent_q[i] == key);
   end

   assign hit     = match & en_q;
   assign rd_data = ent_q[rd_idx];
endmodule

// File: rtl/afc_loader.sv
module afc_loader
   import afc_pkg::*;
#(
   parameter int unsigned PTR_W  = 16,
   parameter int unsigned CNT_W  = 5,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned IDX_W  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                wide,
   input  logic [PTR_W-1:0]    start_ptr,
   input  logic [CNT_W-1:0]    start_cnt,
   output logic                mem_req,
   output logic [PTR_W-1:0]    mem_addr,
   input  logic                mem_ack,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                ent_we,
   output logic [IDX_W-1:0]    ent_idx,
   output logic [3*DATA_W-1:0] ent_data,
   output logic                mask_we,
   output logic [DATA_W-1:0]   mask_data,
   output logic                busy,
   output logic                done
);
   localparam int unsigned        FLD_B  = DATA_W / 8;
   localparam logic [PTR_W-1:0]   STEP_N = PTR_W'(FLD_B);
   localparam logic [PTR_W-1:0]   STEP_W = PTR_W'(2 * FLD_B);

   ld_state_e          st_q;
   logic [PTR_W-1:0]   ptr_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [IDX_W-1:0]   idx_q;
   logic               wide_q;
   logic [1:0]         fld_q;
   logic [DATA_W-1:0]  f1_q, f2_q;
   logic               done_q;
   logic [PTR_W-1:0]   fld_step;
   logic [PTR_W-1:0]   fld_off;
   logic               take;

   assign fld_step = wide_q ? STEP_W : STEP_N;
   assign fld_off  = fld_step * {{(PTR_W-2){1'b0}}, fld_q};
   assign mem_req  = (st_q == LD_FETCH);
   assign mem_addr = ptr_q + fld_off;
   assign take     = mem_req && mem_ack;

   assign ent_we    = take && (fld_q == FLD_HI);
   assign ent_idx   = idx_q;
   assign ent_data  = {mem_rdata, f2_q, f1_q};
   assign mask_we   = take && (fld_q == FLD_MASK);
   assign mask_data = mem_rdata;
   assign busy      = (st_q != LD_IDLE);
   assign done      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= LD_IDLE;
         ptr_q  <= '0;
         cnt_q  <= '0;
         idx_q  <= '0;
         wide_q <= 1'b0;
         fld_q  <= FLD_MASK;
         f1_q   <= '0;
         f2_q   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            LD_IDLE: begin
               if (start) begin
                  ptr_q  <= start_ptr;
                  cnt_q  <= start_cnt;
                  wide_q <= wide;
                  idx_q  <= '0;
                  st_q   <= LD_TEST;
               end
            end
            LD_TEST: begin
               fld_q <= (cnt_q != '0) ? FLD_LO : FLD_MASK;
               st_q  <= LD_FETCH;
            end
            LD_FETCH: begin
               if (mem_ack) begin
                  case (fld_q)
                     FLD_MASK: begin
                        done_q <= 1'b1;
                        st_q   <= LD_IDLE;
                     end
                     FLD_LO: begin
                        f1_q  <= mem_rdata;
                        fld_q <= FLD_MID;
                     end
                     FLD_MID: begin
                        f2_q  <= mem_rdata;
                        fld_q <= FLD_HI;
                     end
                     default: begin
                        idx_q <= idx_q + 1'b1;
                        cnt_q <= cnt_q - 1'b1;
                        ptr_q <= ptr_q + (fld_step << 2);
                        st_q  <= LD_TEST;
                     end
                  endcase
               end
            end
            default: st_q <= LD_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/afc_classify.sv
module afc_classify
   import afc_pkg::*;
#(
   parameter int unsigned AW        = 48,
   parameter int unsigned N_ENTRIES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 key_valid,
   input  logic [AW-1:0]        key,
   input  logic                 promisc,
   input  logic                 all_mcast,
   input  logic                 bcast_en,
   input  logic [N_ENTRIES-1:0] hit,
   output logic                 res_valid,
   output verdict_t             res
);
   verdict_t next_v;
   logic     group_bit;
   logic     is_bcast;

   assign group_bit = key[0];
   assign is_bcast  = &key;

   always_comb begin
      next_v = '0;
      if (promisc && !group_bit) begin
         next_v.accept = 1'b1;
      end else if (all_mcast && group_bit) begin
         next_v.accept = 1'b1;
         next_v.mcast  = 1'b1;
      end else if (bcast_en && is_bcast) begin
         next_v.accept = 1'b1;
         next_v.bcast  = 1'b1;
      end else begin
         next_v.accept = |hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res       <= '0;
      end else begin
         res_valid <= key_valid;
         res       <= key_valid ? next_v : '0;
      end
   end
endmodule

// File: rtl/addr_filter_cam.sv
module addr_filter_cam
   import afc_pkg::*;
#(
   parameter int unsigned N_ENTRIES      = 16,
   parameter int unsigned DATA_W         = 16,
   parameter int unsigned PTR_W          = 16,
   parameter int unsigned CNT_W          = 5,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          dst_valid,
   input  logic [3*DATA_W-1:0]           dst_addr,
   input  logic                          mode_promisc,
   input  logic                          mode_all_mcast,
   input  logic                          mode_bcast,
   output logic                          res_valid,
   output logic                          res_accept,
   output logic                          res_mcast,
   output logic                          res_bcast,
   input  logic                          load_start,
   input  logic                          load_wide,
   input  logic [PTR_W-1:0]              load_ptr,
   input  logic [CNT_W-1:0]              load_count,
   output logic                          load_busy,
   output logic                          load_done,
   output logic                          mem_req,
   output logic [PTR_W-1:0]              mem_addr,
   input  logic                          mem_ack,
   input  logic [DATA_W-1:0]             mem_rdata,
   input  logic                          sw_reset,
   input  logic [$clog2(N_ENTRIES)-1:0]  dbg_ptr,
   input  logic [1:0]                    dbg_sel,
   output logic [DATA_W-1:0]             dbg_data
);
   localparam int unsigned AW     = 3 * DATA_W;
   localparam int unsigned IDX_W  = $clog2(N_ENTRIES);
   localparam int unsigned SLICES = AW / DATA_W;

   if (N_ENTRIES > DATA_W) begin : g_chk_mask
      $error("enable mask must fit one descriptor field");
   end
   if ((1 << IDX_W) != N_ENTRIES) begin : g_chk_pow2
      $error("entry count must be a power of two");
   end
   if (AW != 48) begin : g_chk_aw
      $error("three fields must form a 48-bit address");
   end
   if (PTR_W < 8 || CNT_W < 1) begin : g_chk_ptr
      $error("pointer or count too narrow");
   end

   logic                 ent_we;
   logic [IDX_W-1:0]     ent_idx;
   logic [AW-1:0]        ent_data;
   logic                 mask_we;
   logic [DATA_W-1:0]    mask_word;
   logic [N_ENTRIES-1:0] hit;
   logic [AW-1:0]        rd_entry;
   verdict_t             verdict;

   afc_loader #(
      .PTR_W (PTR_W),
      .CNT_W (CNT_W),
      .DATA_W(DATA_W),
      .IDX_W (IDX_W)
   ) u_loader (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (load_start),
      .wide     (load_wide),
      .start_ptr(load_ptr),
      .start_cnt(load_count),
      .mem_req  (mem_req),
      .mem_addr (mem_addr),
      .mem_ack  (mem_ack),
      .mem_rdata(mem_rdata),
      .ent_we   (ent_we),
      .ent_idx  (ent_idx),
      .ent_data (ent_data),
      .mask_we  (mask_we),
      .mask_data(mask_word),
      .busy     (load_busy),
      .done     (load_done)
   );

   afc_cam #(
      .N_ENTRIES     (N_ENTRIES),
      .AW            (AW),
      .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_cam (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ent_we),
      .wr_idx   (ent_idx),
      .wr_data  (ent_data),
      .mask_we  (mask_we),
      .mask_data(mask_word[N_ENTRIES-1:0]),
      .key      (dst_addr),
      .hit      (hit),
      .rd_idx   (dbg_ptr),
      .rd_data  (rd_entry)
   );

   afc_classify #(
      .AW       (AW),
      .N_ENTRIES(N_ENTRIES)
   ) u_classify (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_valid(dst_valid),
      .key      (dst_addr),
      .promisc  (mode_promisc),
      .all_mcast(mode_all_mcast),
      .bcast_en (mode_bcast),
      .hit      (hit),
      .res_valid(res_valid),
      .res      (verdict)
   );

   assign res_accept = verdict.accept;
   assign res_mcast  = verdict.mcast;
   assign res_bcast  = verdict.bcast;

   always_comb begin
      dbg_data = '0;
      if (sw_reset) begin
         for (int k = 0; k < SLICES; k++) begin
            if (dbg_sel == 2'(k)) dbg_data = rd_entry[k*DATA_W +: DATA_W];
         end
      end
   end
endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
   parameter int unsigned PTR_W  = 16,
   parameter int unsigned DATA_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                dst_valid,
   input logic [3*DATA_W-1:0] dst_addr,
   input logic                mode_promisc,
   input logic                mode_all_mcast,
   input logic                res_valid,
   input logic                res_accept,
   input logic                res_mcast,
   input logic                res_bcast,
   input logic                load_busy,
   input logic                load_done,
   input logic                mem_req,
   input logic                mem_ack,
   input logic [PTR_W-1:0]    mem_addr,
   input logic                sw_reset,
   input logic [DATA_W-1:0]   dbg_data
);
   a_r1_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid && mode_promisc && !dst_addr[0] |=> res_accept && !res_mcast && !res_bcast);

   a_r2_mcast_flag: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid && mode_all_mcast && dst_addr[0] |=> res_accept && res_mcast && !res_bcast);

   a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({res_mcast, res_bcast}));

   a_r3_flag_implies_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (res_mcast || res_bcast) |-> res_accept && res_valid);

   a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid |=> res_valid);

   a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      !dst_valid |=> !res_valid && !res_accept);

   a_r8_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> load_busy);

   a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

   a_r8_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(load_busy) |-> load_done);

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> !load_busy ##1 !load_done);

   a_r9_dbg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_reset |-> dbg_data == '0);
endmodule

bind addr_filter_cam afc_checker #(
   .PTR_W (PTR_W),
   .DATA_W(DATA_W)
) u_afc_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .dst_valid     (dst_valid),
   .dst_addr      (dst_addr),
   .mode_promisc  (mode_promisc),
   .mode_all_mcast(mode_all_mcast),
   .res_valid     (res_valid),
   .res_accept    (res_accept),
   .res_mcast     (res_mcast),
   .res_bcast     (res_bcast),
   .load_busy     (load_busy),
   .load_done     (load_done),
   .mem_req       (mem_req),
   .mem_ack       (mem_ack),
   .mem_addr      (mem_addr),
   .sw_reset      (sw_reset),
   .dbg_data      (dbg_data)
);

// File: tb/addr_filter_cam_bench.sv
`timescale 1ns/1ps
module addr_filter_cam_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dst_valid = 1'b0;
   logic [47:0] dst_addr = '0;
   logic        mode_promisc = 1'b0, mode_all_mcast = 1'b0, mode_bcast = 1'b0;
   logic        res_valid, res_accept, res_mcast, res_bcast;
   logic        load_start = 1'b0, load_wide = 1'b0;
   logic [15:0] load_ptr = '0;
   logic [4:0]  load_count = '0;
   logic        load_busy, load_done;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic        sw_reset = 1'b0;
   logic [3:0]  dbg_ptr = '0;
   logic [1:0]  dbg_sel = '0;
   logic [15:0] dbg_data;

   int n_chk = 0;
   int n_fail = 0;

   logic [15:0] mem [0:1023];
   logic [47:0] exp_ent [16];
   logic [15:0] exp_mask;
   int          lat;

   always #2 clk = ~clk;

   addr_filter_cam u_addr_filter_cam (.*);

   // memory model: acknowledge two cycles after request
   always @(posedge clk) begin
      if (mem_ack) begin
         mem_ack <= 1'b0;
         lat     <= 0;
      end else if (mem_req) begin
         if (lat == 2) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[10:1]];
         end else begin
            lat <= lat + 1;
         end
      end else begin
         lat <= 0;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [47:0] mk_addr(input int i, input int seed);
      logic [7:0] b0;
      b0 = (i == 5) ? 8'h01 : 8'h02;
      return {8'(seed), 8'(i * 7 + seed), 8'h9A, 8'(seed ^ i), 8'(i), b0};
   endfunction

   // writes a table image into memory and updates the bench's expected table
   task automatic prep(input int base, input int cnt, input bit wide, input int seed,
                       input logic [15:0] maskv);
      int fs, st;
      logic [47:0] a;
      fs = wide ? 4 : 2;
      st = wide ? 16 : 8;
      for (int w = 0; w < 8; w++) mem[(base + st * cnt) / 2 + w] = 16'hFFFF;
      for (int i = 0; i < cnt; i++) begin
         a = mk_addr(i, seed);
         for (int w = 0; w < st / 2; w++) mem[(base + st * i) / 2 + w] = 16'hFFFF;
         mem[(base + st * i) / 2]          = 16'hBEEF;
         mem[(base + st * i + fs) / 2]     = a[15:0];
         mem[(base + st * i + 2 * fs) / 2] = a[31:16];
         mem[(base + st * i + 3 * fs) / 2] = a[47:32];
         exp_ent[i % 16] = a;
      end
      mem[(base + st * cnt) / 2] = maskv;
      exp_mask = maskv;
   endtask

   task automatic run_load(input int base, input int cnt_field, input bit wide, input string tag);
      int guard;
      @(negedge clk);
      load_ptr   = 16'(base);
      load_count = 5'(cnt_field);
      load_wide  = wide;
      load_start = 1'b1;
      @(negedge clk);
      load_start = 1'b0;
      chk({tag, " busy"}, 64'(load_busy), 64'd1);
      guard = 0;
      while (!load_done && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      chk({tag, " R8 done seen"}, 64'(load_done), 64'd1);
      chk("R8 busy low with done", 64'(load_busy), 64'd0);
      @(negedge clk);
      chk("R8 done one cycle", 64'(load_done), 64'd0);
   endtask

   task automatic dbg_sweep(input string tag);
      @(negedge clk);
      sw_reset = 1'b1;
      for (int e = 0; e < 16; e++) begin
         for (int k = 0; k < 4; k++) begin
            dbg_ptr = 4'(e);
            dbg_sel = 2'(k);
            #1;
            if (k < 3) chk({tag, " R9 slice"}, 64'(dbg_data), 64'(exp_ent[e][16*k +: 16]));
            else       chk("R9 slice 3 zero", 64'(dbg_data), 64'd0);
         end
      end
      dbg_ptr = 4'd1;
      dbg_sel = 2'd0;
      sw_reset = 1'b0;
      #1;
      chk("R9 outside reset", 64'(dbg_data), 64'd0);
   endtask

   function automatic logic [2:0] exp_filter(input logic [47:0] a, input bit p, input bit m,
                                             input bit b);
      if (p && !a[0]) return 3'b100;
      if (m && a[0]) return 3'b110;
      if (b && (&a)) return 3'b101;
      for (int i = 0; i < 16; i++)
         if (exp_mask[i] && exp_ent[i] == a) return 3'b100;
      return 3'b000;
   endfunction

   function automatic string rule_tag(input logic [47:0] a, input bit p, input bit m, input bit b);
      if (p && !a[0]) return "R1";
      if (m && a[0]) return "R2";
      if (b && (&a)) return "R3";
      return "R4";
   endfunction

   task automatic send(input logic [47:0] a, input bit p, input bit m, input bit b);
      @(negedge clk);
      dst_addr = a;
      mode_promisc = p;
      mode_all_mcast = m;
      mode_bcast = b;
      dst_valid = 1'b1;
      @(negedge clk);
      dst_valid = 1'b0;
      chk("R5 valid", 64'(res_valid), 64'd1);
      chk(rule_tag(a, p, m, b), 64'({res_accept, res_mcast, res_bcast}), 64'(exp_filter(a, p, m, b)));
   endtask

   task automatic mode_sweep();
      logic [47:0] vec [20];
      for (int i = 0; i < 16; i++) vec[i] = exp_ent[i];
      vec[16] = 48'hFFFF_FFFF_FFFF;
      vec[17] = 48'h0000_1234_5678_ABCE;
      vec[18] = 48'h0000_5E00_0000_0033;
      vec[19] = 48'hFFFF_FFFF_FFFE;
      for (int md = 0; md < 8; md++)
         for (int v = 0; v < 20; v++)
            send(vec[v], md[2], md[1], md[0]);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 16'h3A5 + 16'h11);
      for (int i = 0; i < 16; i++) exp_ent[i] = '0;
      exp_mask = '0;
      repeat (3) @(negedge clk);
      chk("R5 reset valid", 64'(res_valid), 64'd0);
      chk("R8 reset busy", 64'(load_busy), 64'd0);
      chk("R8 reset req", 64'(mem_req), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      dbg_sweep("R7 reset table");
      // a zero table with zero mask rejects everything
      send(48'h0, 1'b0, 1'b0, 1'b0);

      // R6 narrow load of all 16 entries
      prep(16'h040, 16, 1'b0, 8'h21, 16'hA5B7);
      run_load(16'h040, 16, 1'b0, "R6 narrow");
      dbg_sweep("R6 narrow");
      mode_sweep();

      // R5 result lasts one cycle only
      send(exp_ent[0], 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      chk("R5 valid single", 64'(res_valid), 64'd0);

      // R6 wide spacing, R7 entries beyond count preserved
      prep(16'h200, 3, 1'b1, 8'h44, 16'h00FF);
      run_load(16'h200, 3, 1'b1, "R6 wide");
      dbg_sweep("R7 wide keep");
      mode_sweep();

      // R7 count of zero loads only the mask
      prep(16'h380, 0, 1'b0, 8'h00, 16'h0F0F);
      run_load(16'h380, 0, 1'b0, "R7 zero count");
      dbg_sweep("R7 zero count");
      mode_sweep();

      // R6 start ignored while busy: second start leaves loaded image
      prep(16'h300, 2, 1'b0, 8'h66, 16'hFFFF);
      @(negedge clk);
      load_ptr = 16'h300; load_count = 5'd2; load_wide = 1'b0; load_start = 1'b1;
      @(negedge clk);
      load_ptr = 16'h000; load_count = 5'd9;
      @(negedge clk);
      load_start = 1'b0;
      while (!load_done) @(negedge clk);
      @(negedge clk);
      chk("R8 idle after load", 64'(load_busy), 64'd0);
      dbg_sweep("R6 restart ignored");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule